// File: doc/BRIEF.md
# Multiplexed External Memory Read Sequencer

This block runs the bus cycle that fetches one 16-bit word from external program memory. The memory sits on a 20-bit address bus. Its low 16 bits share pins with the data, so the same wires carry the address and then the returned word. A fetch request supplies the full address. The sequencer then does the following, in order:

- puts the top four address bits on dedicated lines;
- drives the low sixteen bits on the shared lines and marks them with an address-latch strobe;
- releases the shared lines;
- pulses an active-low output enable toward the memory;
- captures the word when the enable rises.

It reports the word with a one-tick valid pulse.

The block runs on a tick clock with eight ticks per instruction cycle, so one read takes exactly eight ticks. Every strobe edge falls on a tick boundary:

| Tick | Event |
|------|-------|
| 0 | Address is driven and the latch strobe goes high. |
| 2 | The latch strobe falls and the shared lines are released. |
| 3 | The output enable goes low. |
| 7 | The output enable rises and the data is sampled. |

A one-entry holding slot accepts one further request while a cycle is in progress. That request starts on the tick right after the current cycle ends.

Top module: `xmem_read_seq`

## Requirements
- R1: While reset is active and after its release with no request, `ale` is 0, `ce_n` is 1, `oe_n` is 1, `ad_oe` is 0, `ad_out` is 0, `rd_valid` is 0, `rd_data` is 0, `addr_hi` is 0 and `req_ready` is 1.
- R2: A request accepted while idle starts a cycle on the next tick (tick 0). During ticks 0 and 1, `ad_out` equals address bits 15:0 and `ad_oe` is 1. When `ad_oe` is 0, `ad_out` reads 0.
- R3: `ale` is 1 during ticks 0 and 1 of every cycle. `ale` falls at tick 2 on the same tick that `ad_oe` drops to 0.
- R4: `oe_n` is 0 during ticks 3 to 6, which is four ticks and begins one tick after `ale` falls. `oe_n` and `ad_oe` are never active together.
- R5: At the edge where `oe_n` returns to 1 (entering tick 7), `rd_data` loads the value on `ad_in` during tick 6. `rd_valid` is 1 for exactly that tick 7. `rd_data` holds its value until the next capture.
- R6: `ce_n` is 0 for all eight ticks of a cycle, including the ticks where `ale` is high.
- R7: A request accepted during a cycle, or at its tick 7, starts the next cycle at the tick after tick 7. The shared lines are then driven again one tick after `oe_n` rose. Every accepted request yields exactly one capture.
- R8: `req_ready` is 0 exactly while the holding slot contains a request. A request presented while `req_ready` is 0 is not accepted and produces no cycle.
- R9: `addr_hi` carries address bits 19:16 from tick 0 of a cycle until the next cycle begins, and holds that value while idle.
- R10: With no accepted request, `ce_n` stays 1 and no strobe toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, eight ticks per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 20 | Full word address of the fetch |
| req_ready | output | 1 | Request is accepted when high together with req_valid |
| addr_hi | output | 4 | Dedicated upper address lines |
| ad_out | output | 16 | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Drive enable for the shared lines (0 = high impedance) |
| ad_in | input | 16 | Value seen on the shared lines |
| ale | output | 1 | Address latch strobe, address taken on its falling edge |
| ce_n | output | 1 | Active-low memory select |
| oe_n | output | 1 | Active-low memory output enable |
| rd_data | output | 16 | Last captured word |
| rd_valid | output | 1 | One-tick pulse when rd_data is updated |

## Verification
The assertions assume that the memory model answers only while `oe_n` is low. They also assume that a request is counted only when `req_ready` is high, so the holding slot can never overflow. The bench's memory model copies this behaviour. It latches the address from the shared lines while the latch strobe is high. It drives the returned word only during the enable window and drives a distinct filler pattern otherwise, so any sample taken at the wrong tick shows up as wrong data. Requests are issued as isolated pulses, as a second pulse during a running cycle, as a request held high over hundreds of ticks, and as sparse random traffic. This mix makes requests land on every tick of the cycle, including tick 7 and the ticks while the slot is full.

// File: rtl/xmr_pkg.sv
package xmr_pkg;

    // Coarse position inside one read cycle, derived from the tick count
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_TURN,
        PH_READ,
        PH_DONE
    } xmr_phase_e;

endpackage

// File: rtl/xmr_req_slot.sv
module xmr_req_slot #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic              full,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        logic              full;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    slot_t slot_q, slot_d;

    always_comb begin
        slot_d = slot_q;
        if (pop) begin
            slot_d.full = 1'b0;
        end
        if (push) begin
            slot_d.full = 1'b1;
            slot_d.addr = push_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign full = slot_q.full;
    assign addr = slot_q.addr;

endmodule

// File: rtl/xmr_strobe_gen.sv
module xmr_strobe_gen
    import xmr_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int ALE_FALL = 2,
    parameter int OE_FALL  = 3,
    parameter int OE_RISE  = 7
) (
    input  logic             active,
    input  logic [CNT_W-1:0] tick,
    output logic             ale,
    output logic             addr_drive,
    output logic             ce_n,
    output logic             oe_n,
    output logic             cap_en
);

    xmr_phase_e phase;
    int         t;

    always_comb begin
        t = int'(tick);
        if (!active) begin
            phase = PH_IDLE;
        end else if (t < ALE_FALL) begin
            phase = PH_ADDR;
        end else if (t < OE_FALL) begin
            phase = PH_TURN;
        end else if (t < OE_RISE) begin
            phase = PH_READ;
        end else begin
            phase = PH_DONE;
        end
    end

    always_comb begin
        ale        = (phase == PH_ADDR);
        addr_drive = (phase == PH_ADDR);
        ce_n       = (phase == PH_IDLE);
        oe_n       = (phase != PH_READ);
        cap_en     = (phase == PH_READ) && (t == OE_RISE - 1);
    end

endmodule

// File: rtl/xmr_capture.sv
module xmr_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_q, cap_d;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = cap_en;
        if (cap_en) begin
            cap_d.data = ad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.valid;

endmodule

// File: rtl/xmem_read_seq.sv
module xmem_read_seq #(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 16,
    parameter int TICKS_PER_CYC = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     req_ready,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     ce_n,
    output logic                     oe_n,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid
);

    localparam int CNT_W    = $clog2(TICKS_PER_CYC);
    localparam int LAST     = TICKS_PER_CYC - 1;
    localparam int ALE_FALL = TICKS_PER_CYC / 4;
    localparam int OE_FALL  = ALE_FALL + TICKS_PER_CYC / 8;
    localparam int OE_RISE  = OE_FALL + TICKS_PER_CYC / 2;

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  tick;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_q, seq_d;

    logic              slot_full;
    logic [ADDR_W-1:0] slot_addr;
    logic              accept;
    logic              direct;
    logic              pop;
    logic              push;
    logic              addr_drive;
    logic              cap_en;

    assign req_ready = !slot_full;
    assign accept    = req_valid && !slot_full;

    // Next cycle state: start from idle, chain at the last tick, else advance
    always_comb begin
        seq_d  = seq_q;
        direct = 1'b0;
        pop    = 1'b0;
        if (!seq_q.active) begin
            if (accept) begin
                seq_d.active = 1'b1;
                seq_d.tick   = '0;
                seq_d.addr   = req_addr;
                direct       = 1'b1;
            end
        end else if (seq_q.tick == CNT_W'(LAST)) begin
            seq_d.tick = '0;
            if (slot_full) begin
                seq_d.addr = slot_addr;
                pop        = 1'b1;
            end else if (accept) begin
                seq_d.addr = req_addr;
                direct     = 1'b1;
            end else begin
                seq_d.active = 1'b0;
            end
        end else begin
            seq_d.tick = seq_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign push = accept && !direct;

    xmr_req_slot #(
        .ADDR_W (ADDR_W)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (req_addr),
        .pop       (pop),
        .full      (slot_full),
        .addr      (slot_addr)
    );

    xmr_strobe_gen #(
        .CNT_W    (CNT_W),
        .ALE_FALL (ALE_FALL),
        .OE_FALL  (OE_FALL),
        .OE_RISE  (OE_RISE)
    ) u_strobe (
        .active     (seq_q.active),
        .tick       (seq_q.tick),
        .ale        (ale),
        .addr_drive (addr_drive),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .cap_en     (cap_en)
    );

    xmr_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .ad_in    (ad_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign ad_oe   = addr_drive;
    assign ad_out  = addr_drive ? seq_q.addr[DATA_W-1:0] : '0;
    assign addr_hi = seq_q.addr[ADDR_W-1:DATA_W];

endmodule

// File: rtl/xmr_read_chk.sv
module xmr_read_chk #(
    parameter int HI_W         = 4,
    parameter int OE_LOW_TICKS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic            ce_n,
    input logic            oe_n,
    input logic            ad_oe,
    input logic            rd_valid,
    input logic            req_ready,
    input logic [HI_W-1:0] addr_hi
);

    int oe_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_run_q <= 0;
        end else if (oe_n) begin
            oe_run_q <= 0;
        end else begin
            oe_run_q <= oe_run_q + 1;
        end
    end

    // R4
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ad_oe && !oe_n));

    // R3
    ale_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> !ad_oe);

    // R4
    oe_follows_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |=> $fell(oe_n));

    // R4
    oe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_run_q == OE_LOW_TICKS));

    // R5
    valid_at_oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> rd_valid);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6
    ce_with_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !ce_n);

    // R8
    slot_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !ce_n);

    // R9
    upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(!ale)) |-> $stable(addr_hi));

endmodule

bind xmem_read_seq xmr_read_chk #(
    .HI_W (ADDR_W - DATA_W)
) u_read_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .ad_oe     (ad_oe),
    .rd_valid  (rd_valid),
    .req_ready (req_ready),
    .addr_hi   (addr_hi)
);

// File: tb/tb_xmem_read_seq.sv
`timescale 1ns/1ps
module tb_xmem_read_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_ready;
    logic [3:0]  addr_hi;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in;
    logic        ale;
    logic        ce_n;
    logic        oe_n;
    logic [15:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    xmem_read_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ad_in     (ad_in),
        .ale       (ale),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    function automatic logic [15:0] mem_word(logic [19:0] a);
        return a[15:0] ^ {a[3:0], 8'h5A, a[19:16]};
    endfunction

    // Memory model: latch address while the strobe is high, answer only with OE low
    logic [19:0] mem_lat = '0;
    always @(negedge clk) if (ale && ad_oe) mem_lat = {addr_hi, ad_out};
    assign ad_in = !oe_n ? mem_word(mem_lat) : 16'hDEAD;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: tick position, queue of waiting addresses
    bit          m_active = 0;
    int          m_tick = 0;
    logic [19:0] m_addr = '0;
    logic [19:0] m_q[$];
    bit          m_vld = 0;
    logic [15:0] m_data = '0;
    int          m_accepted = 0;
    int          seen_pulses = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_tick = 0; m_addr = '0; m_q.delete();
            m_vld = 0; m_data = '0; m_accepted = 0;
        end else begin
            bit acc;
            acc = req_valid && (m_q.size() == 0);
            if (acc) m_accepted++;
            m_vld = m_active && (m_tick == 6);
            if (m_vld) m_data = mem_word(m_addr);
            if (!m_active) begin
                if (acc) begin m_active = 1; m_tick = 0; m_addr = req_addr; end
            end else if (m_tick == 7) begin
                m_tick = 0;
                if (m_q.size() != 0) m_addr = m_q.pop_front();
                else if (acc) m_addr = req_addr;
                else m_active = 0;
            end else begin
                m_tick++;
                if (acc) m_q.push_back(req_addr);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_drive;
            e_drive = m_active && (m_tick < 2);
            chk("R2 ad_out", ad_out, e_drive ? m_addr[15:0] : 16'h0);
            chk("R3 ale", ale, e_drive);
            chk("R3 ad_oe", ad_oe, e_drive);
            chk("R4 oe_n", oe_n, !(m_active && m_tick >= 3 && m_tick <= 6));
            chk("R6 ce_n", ce_n, !m_active);
            chk("R9 addr_hi", addr_hi, m_addr[19:16]);
            chk("R8 req_ready", req_ready, m_q.size() == 0);
            chk("R5 rd_valid", rd_valid, m_vld);
            chk("R5 rd_data", rd_data, m_data);
            if (rd_valid) seen_pulses++;
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_req(input logic [19:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        ticks(3);
        chk("R1 ale", ale, 0);
        chk("R1 ce_n", ce_n, 1);
        chk("R1 oe_n", oe_n, 1);
        chk("R1 ad_oe", ad_oe, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 req_ready", req_ready, 1);
        chk("R1 ad_out", ad_out, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 addr_hi", addr_hi, 0);
        rst_n = 1'b1;
        // R10 idle with no request
        ticks(10);
        chk("R10 idle ce_n", ce_n, 1);
        chk("R10 idle ale", ale, 0);
        // R2 single request from idle
        pulse_req(20'hABCDE);
        ticks(12);
        chk("R5 single data", rd_data, mem_word(20'hABCDE));
        // R7 second request queued mid-cycle
        pulse_req(20'h12345);
        ticks(2);
        pulse_req(20'h6789A);
        ticks(20);
        chk("R7 chained data", rd_data, mem_word(20'h6789A));
        // R8 request held high: only accepted ones run
        @(negedge clk);
        req_valid = 1'b1;
        for (int i = 0; i < 300; i++) begin
            req_addr = 20'($urandom);
            @(negedge clk);
        end
        req_valid = 1'b0;
        ticks(24);
        // sparse random traffic on every tick position
        for (int i = 0; i < 2000; i++) begin
            req_valid = ($urandom % 10) < 3;
            req_addr  = 20'($urandom);
            @(negedge clk);
        end
        req_valid = 1'b0;
        ticks(30);
        // R7 one capture per accepted request; R8 ignored requests made none
        chk("R7 capture count", seen_pulses, m_accepted);
        chk("R10 drained ce_n", ce_n, 1);
        finish_run();
    end

endmodule